// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Delayed Reset

This block watches for software lockup. A free-running interval counter runs whenever at least one of its two enables is set. When the selected interval elapses, the block sets an interrupt flag. If reset is enabled, it also starts a second, fixed countdown of 512 clocks. When that countdown expires, the block drives a reset-hold output for 12 clocks and records that a watchdog reset took place. Software keeps the timer from expiring by writing the restart bit. Software can also clear reset enable during the countdown to call the reset off.

The block has a single 8-bit control register, which is read and written in whole. The interrupt request is qualified by a global enable, a system mask and an in-service input. There are two reset inputs. The power-on reset clears everything. The other reset keeps the enables and the reset flag, because a watchdog reset must still be visible after the reset it caused.

The controller has four states:
- `WD_IDLE`: stopped.
- `WD_RUN`: the interval counter is counting.
- `WD_ARMED`: the 512-clock countdown is running.
- `WD_HOLD`: the reset output is driven.

It moves between them as follows:
- idle→run when an enable is set.
- idle→armed when an enable is set in the same write that also sets the interrupt flag with reset enabled.
- run→idle when both enables are cleared.
- run→armed on a timeout with reset enabled, or when software sets the flag with reset enabled.
- armed→run, or armed→idle, when reset enable is cleared.
- armed→hold when the countdown expires.
- hold→run, or hold→idle, after 12 clocks, with both counters cleared.

Top module: `wdt_delayed_reset`

## Requirements
- R1: Writing a 1 in bit 0 clears the interval count, so the next timeout comes a full interval after that write. Bit 0 always reads 0.
- R2: When the interval elapses, or when software writes 1 to the interrupt flag (bit 6) while it is 0, and reset enable (bit 1) is 1, the reset-hold output rises 512 clocks after that edge. With reset enable at 0, no reset follows.
- R3: With reset enable and interrupt enable (bit 2) both 0, both counters hold their values. Setting either enable from this state clears both counters and starts a full interval.
- R4: Changing the interval select (bits 4:3) restarts the interval count while counting. During the 512-clock countdown, the change has no effect on either count.
- R5: The reset flag (bit 5) is set by hardware only when a watchdog reset occurs. Software writing 1 to it causes no reset.
- R6: A watchdog reset holds the reset-hold output high for exactly 12 clocks.
- R7: The interrupt request is high exactly when all of the following hold: interrupt flag = 1, interrupt enable = 1, global enable = 1, mask = 1, and in-service = 0.
- R8: The register layout is:
  - bit 0: restart
  - bit 1: reset enable
  - bit 2: interrupt enable
  - bits 4:3: interval select
  - bit 5: reset flag
  - bit 6: interrupt flag
  - bit 7: power-on flag

  Power-on reset gives 0x80. The other reset clears only the interrupt flag and the interval select. It leaves the enables, the reset flag and the power-on flag unchanged.
- R9: Interval select code c gives a timeout of 2^(BASE_EXP+3c) clocks after the start. With the default BASE_EXP = 12, codes 0 to 3 give 2^12, 2^15, 2^18 and 2^21 clocks.
- R10: Clearing reset enable during the 512-clock countdown cancels the pending reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| rst_n | input | 1 | Any other reset, active low, synchronous |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 8 | Write data for the control register |
| rd_data | output | 8 | Current control register value |
| glb_irq_en | input | 1 | Global interrupt enable |
| irq_mask | input | 1 | System interrupt mask, 1 = allowed |
| irq_in_service | input | 1 | An interrupt is already being serviced |
| irq_req | output | 1 | Qualified watchdog interrupt request |
| rst_hold | output | 1 | Reset pulse, 12 clocks long |

## Verification
The interval counter is started from the stopped state with each of the three shortest select codes. Each run checks the cycle before and the cycle of the timeout, which separates an off-by-one from a wrong code decode. Restart writes and select changes are placed one cycle before the original timeout would have occurred, so a counter that ignored them would be caught. The same select change placed during the countdown must leave the reset edge exactly where it was. The reset path is entered in two ways, by a timeout and by a software-set flag, and is also cancelled mid-countdown, so that a scheduled reset can be told apart from a spurious one and from one that cannot be cancelled. A table of gating patterns toggles each interrupt qualifier on its own.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_RUN   = 2'd1,
        WD_ARMED = 2'd2,
        WD_HOLD  = 2'd3
    } wd_state_e;

    localparam int unsigned BIT_RESTART = 0;
    localparam int unsigned BIT_RST_EN  = 1;
    localparam int unsigned BIT_IRQ_EN  = 2;
    localparam int unsigned BIT_SEL_LO  = 3;
    localparam int unsigned BIT_SEL_HI  = 4;
    localparam int unsigned BIT_RST_FLG = 5;
    localparam int unsigned BIT_IRQ_FLG = 6;
    localparam int unsigned BIT_POR_FLG = 7;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       rst_n,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    input  logic       tmo_i,
    input  logic       fire_i,
    output logic       rst_en_nx_o,
    output logic       irq_en_nx_o,
    output logic       restart_o,
    output logic       sel_chg_o,
    output logic       sw_irq_o,
    output logic [1:0] sel_o,
    output logic       irq_flag_o,
    output logic [7:0] rd_data_o
);
    logic       rst_en_q, irq_en_q, rst_flag_q, irq_flag_q, por_flag_q;
    logic [1:0] sel_q;

    always_ff @(posedge clk) begin
        if (!por_n) begin
            rst_en_q   <= 1'b0;
            irq_en_q   <= 1'b0;
            sel_q      <= 2'b00;
            rst_flag_q <= 1'b0;
            irq_flag_q <= 1'b0;
            por_flag_q <= 1'b1;
        end else if (!rst_n) begin
            sel_q      <= 2'b00;
            irq_flag_q <= 1'b0;
        end else begin
            if (wr_en_i) begin
                rst_en_q   <= wr_data_i[BIT_RST_EN];
                irq_en_q   <= wr_data_i[BIT_IRQ_EN];
                sel_q      <= wr_data_i[BIT_SEL_HI:BIT_SEL_LO];
                rst_flag_q <= wr_data_i[BIT_RST_FLG];
                irq_flag_q <= wr_data_i[BIT_IRQ_FLG];
                por_flag_q <= wr_data_i[BIT_POR_FLG];
            end
            if (tmo_i)  irq_flag_q <= 1'b1;
            if (fire_i) rst_flag_q <= 1'b1;
        end
    end

    assign rst_en_nx_o = wr_en_i ? wr_data_i[BIT_RST_EN] : rst_en_q;
    assign irq_en_nx_o = wr_en_i ? wr_data_i[BIT_IRQ_EN] : irq_en_q;
    assign restart_o   = wr_en_i & wr_data_i[BIT_RESTART];
    assign sel_chg_o   = wr_en_i & (wr_data_i[BIT_SEL_HI:BIT_SEL_LO] != sel_q);
    assign sw_irq_o    = wr_en_i & wr_data_i[BIT_IRQ_FLG] & ~irq_flag_q;
    assign sel_o       = sel_q;
    assign irq_flag_o  = irq_flag_q;
    assign rd_data_o   = {por_flag_q, irq_flag_q, rst_flag_q, sel_q,
                          irq_en_q, rst_en_q, 1'b0};

    // R5: the reset flag moves only on a watchdog reset or a register write
    assert_rst_flag_src_R5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (!fire_i && !wr_en_i) |=> $stable(rst_flag_q));
endmodule

// File: rtl/wdt_seq.sv
module wdt_seq
    import wdt_pkg::*;
#(
    parameter int unsigned BASE_EXP    = 12,
    parameter int unsigned ARM_CYCLES  = 512,
    parameter int unsigned HOLD_CYCLES = 12
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       rst_n,
    input  logic       rst_en_i,
    input  logic       irq_en_i,
    input  logic       restart_i,
    input  logic       sel_chg_i,
    input  logic       sw_irq_i,
    input  logic [1:0] sel_i,
    output logic       tmo_o,
    output logic       fire_o,
    output logic       hold_o
);
    localparam int unsigned IW = BASE_EXP + 10;
    localparam int unsigned AW = $clog2(ARM_CYCLES);
    localparam int unsigned HW = $clog2(HOLD_CYCLES);

    wd_state_e         state_q, state_d;
    logic [IW-1:0]     icnt_q, icnt_d;
    logic [AW-1:0]     acnt_q, acnt_d;
    logic [HW-1:0]     hcnt_q, hcnt_d;
    logic [IW-1:0]     lim_tab [4];
    logic [IW-1:0]     lim;
    logic              run_en;

    for (genvar g = 0; g < 4; g++) begin : g_lim
        assign lim_tab[g] = {{(IW-1){1'b0}}, 1'b1} << (BASE_EXP + 3*g);
    end

    assign lim    = lim_tab[sel_i];
    assign run_en = rst_en_i | irq_en_i;

    always_ff @(posedge clk) begin
        if (!por_n) begin
            state_q <= WD_IDLE;
            icnt_q  <= '0;
            acnt_q  <= '0;
            hcnt_q  <= '0;
        end else if (!rst_n) begin
            state_q <= run_en ? WD_RUN : WD_IDLE;
            icnt_q  <= '0;
            acnt_q  <= '0;
            hcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            icnt_q  <= icnt_d;
            acnt_q  <= acnt_d;
            hcnt_q  <= hcnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        icnt_d  = icnt_q;
        acnt_d  = acnt_q;
        hcnt_d  = hcnt_q;
        tmo_o   = 1'b0;
        fire_o  = 1'b0;
        unique case (state_q)
            WD_IDLE: begin
                if (run_en) begin
                    icnt_d  = '0;
                    acnt_d  = '0;
                    state_d = (sw_irq_i && rst_en_i) ? WD_ARMED : WD_RUN;
                end
            end
            WD_RUN: begin
                if (!run_en) begin
                    state_d = WD_IDLE;
                end else if (sw_irq_i && rst_en_i) begin
                    state_d = WD_ARMED;
                    acnt_d  = '0;
                end else if (restart_i || sel_chg_i) begin
                    icnt_d = '0;
                end else if (icnt_q == lim - IW'(1)) begin
                    tmo_o  = 1'b1;
                    icnt_d = '0;
                    if (rst_en_i) begin
                        state_d = WD_ARMED;
                        acnt_d  = '0;
                    end
                end else begin
                    icnt_d = icnt_q + IW'(1);
                end
            end
            WD_ARMED: begin
                if (restart_i) icnt_d = '0;
                if (!rst_en_i) begin
                    state_d = irq_en_i ? WD_RUN : WD_IDLE;
                end else if (acnt_q == AW'(ARM_CYCLES - 1)) begin
                    fire_o  = 1'b1;
                    state_d = WD_HOLD;
                    hcnt_d  = '0;
                end else begin
                    acnt_d = acnt_q + AW'(1);
                end
            end
            WD_HOLD: begin
                if (hcnt_q == HW'(HOLD_CYCLES - 1)) begin
                    state_d = run_en ? WD_RUN : WD_IDLE;
                    icnt_d  = '0;
                    acnt_d  = '0;
                end else begin
                    hcnt_d = hcnt_q + HW'(1);
                end
            end
            default: state_d = WD_IDLE;
        endcase
    end

    assign hold_o = (state_q == WD_HOLD);

    // R6: the hold state is not left before its count completes
    assert_hold_len_R6: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (state_q == WD_HOLD && hcnt_q != HW'(HOLD_CYCLES - 1)) |=> state_q == WD_HOLD);
    // R3: a stopped timer keeps both counts
    assert_idle_frozen_R3: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (state_q == WD_IDLE && !run_en) |=> (state_q == WD_IDLE && $stable(icnt_q) && $stable(acnt_q)));
    // R4: an interval change during the countdown leaves the interval count alone
    assert_armed_sel_R4: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (state_q == WD_ARMED && rst_en_i && sel_chg_i && !restart_i) |=> $stable(icnt_q));
    // R1: a restart while counting empties the interval count
    assert_restart_R1: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (state_q == WD_RUN && run_en && restart_i && !(sw_irq_i && rst_en_i)) |=> icnt_q == '0);
    // R10: dropping reset enable during the countdown never reaches the hold state
    assert_cancel_R10: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (state_q == WD_ARMED && !rst_en_i) |=> state_q != WD_HOLD);
endmodule

// File: rtl/wdt_irq_gate.sv
module wdt_irq_gate (
    input  logic irq_flag_i,
    input  logic irq_en_i,
    input  logic glb_en_i,
    input  logic mask_i,
    input  logic in_service_i,
    output logic irq_req_o
);
    assign irq_req_o = irq_flag_i & irq_en_i & glb_en_i & mask_i & ~in_service_i;
endmodule

// File: rtl/wdt_delayed_reset.sv
module wdt_delayed_reset
    import wdt_pkg::*;
#(
    parameter int unsigned BASE_EXP    = 12,
    parameter int unsigned ARM_CYCLES  = 512,
    parameter int unsigned HOLD_CYCLES = 12
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       glb_irq_en,
    input  logic       irq_mask,
    input  logic       irq_in_service,
    output logic       irq_req,
    output logic       rst_hold
);
    logic       rst_en_nx, irq_en_nx, restart, sel_chg, sw_irq, irq_flag;
    logic       tmo, fire;
    logic [1:0] sel;

    wdt_regs u_regs (
        .clk         (clk),
        .por_n       (por_n),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en),
        .wr_data_i   (wr_data),
        .tmo_i       (tmo),
        .fire_i      (fire),
        .rst_en_nx_o (rst_en_nx),
        .irq_en_nx_o (irq_en_nx),
        .restart_o   (restart),
        .sel_chg_o   (sel_chg),
        .sw_irq_o    (sw_irq),
        .sel_o       (sel),
        .irq_flag_o  (irq_flag),
        .rd_data_o   (rd_data)
    );

    wdt_seq #(
        .BASE_EXP    (BASE_EXP),
        .ARM_CYCLES  (ARM_CYCLES),
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_seq (
        .clk       (clk),
        .por_n     (por_n),
        .rst_n     (rst_n),
        .rst_en_i  (rst_en_nx),
        .irq_en_i  (irq_en_nx),
        .restart_i (restart),
        .sel_chg_i (sel_chg),
        .sw_irq_i  (sw_irq),
        .sel_i     (sel),
        .tmo_o     (tmo),
        .fire_o    (fire),
        .hold_o    (rst_hold)
    );

    wdt_irq_gate u_gate (
        .irq_flag_i   (irq_flag),
        .irq_en_i     (rd_data[BIT_IRQ_EN]),
        .glb_en_i     (glb_irq_en),
        .mask_i       (irq_mask),
        .in_service_i (irq_in_service),
        .irq_req_o    (irq_req)
    );
endmodule

// File: tb/wdt_delayed_reset_tb.sv
module wdt_delayed_reset_tb;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       rst_n = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       glb_irq_en = 1'b0;
    logic       irq_mask = 1'b0;
    logic       irq_in_service = 1'b0;
    logic       irq_req;
    logic       rst_hold;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    wdt_delayed_reset #(.BASE_EXP(3)) u_dut (
        .clk            (clk),
        .por_n          (por_n),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_data        (wr_data),
        .rd_data        (rd_data),
        .glb_irq_en     (glb_irq_en),
        .irq_mask       (irq_mask),
        .irq_in_service (irq_in_service),
        .irq_req        (irq_req),
        .rst_hold       (rst_hold)
    );

    // {irq_en, global, mask, in_service, expected request}
    localparam logic [4:0] GATE_VEC [8] = '{
        5'b1_1_1_0_1, 5'b0_1_1_0_0, 5'b1_0_1_0_0, 5'b1_1_0_0_0,
        5'b1_1_1_1_0, 5'b1_0_0_1_0, 5'b0_0_0_0_0, 5'b1_1_1_0_1
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_por();
        @(negedge clk);
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
    endtask

    task automatic hold_never(input string tag, input int n);
        logic seen;
        seen = 1'b0;
        repeat (n) begin
            @(negedge clk);
            if (rst_hold) seen = 1'b1;
        end
        chk(tag, 32'(seen), 32'h0);
    endtask

    initial begin
        cyc(3);
        por_n = 1'b1;
        cyc(1);
        chk("R8 power-on register value", 32'(rd_data), 32'h80);
        chk("R8 no hold after power-on", 32'(rst_hold), 32'h0);
        chk("R7 no request after power-on", 32'(irq_req), 32'h0);

        // R9 code 0: 8 clocks
        wr(8'h04);
        cyc(7); chk("R9 code0 before timeout", 32'(rd_data[6]), 32'h0);
        cyc(1); chk("R9 code0 at timeout", 32'(rd_data[6]), 32'h1);
        hold_never("R2 no reset with reset disabled", 600);
        chk("R5 flag clear without reset", 32'(rd_data[5]), 32'h0);

        // R9 code 1: 64 clocks
        wr(8'h00);
        chk("R3 stop and clear", 32'(rd_data), 32'h00);
        wr(8'h0C);
        cyc(63); chk("R9 code1 before timeout", 32'(rd_data[6]), 32'h0);
        cyc(1);  chk("R9 code1 at timeout", 32'(rd_data[6]), 32'h1);

        // R9 code 2: 512 clocks
        wr(8'h00);
        wr(8'h14);
        cyc(511); chk("R9 code2 before timeout", 32'(rd_data[6]), 32'h0);
        cyc(1);   chk("R9 code2 at timeout", 32'(rd_data[6]), 32'h1);

        // R3: stopping freezes, re-enabling starts a full interval
        wr(8'h00);
        wr(8'h04);
        cyc(5);
        wr(8'h00);
        cyc(100); chk("R3 stopped timer sets no flag", 32'(rd_data[6]), 32'h0);
        wr(8'h04);
        cyc(7); chk("R3 restart from stop, before", 32'(rd_data[6]), 32'h0);
        cyc(1); chk("R3 restart from stop, at", 32'(rd_data[6]), 32'h1);

        // R1: restart one clock before the original timeout
        wr(8'h00);
        wr(8'h04);
        cyc(5);
        wr(8'h05);
        chk("R1 restart bit reads 0", 32'(rd_data), 32'h04);
        cyc(7); chk("R1 no timeout before full interval", 32'(rd_data[6]), 32'h0);
        cyc(1); chk("R1 timeout after full interval", 32'(rd_data[6]), 32'h1);

        // R4: select change while counting restarts the count
        wr(8'h00);
        wr(8'h04);
        cyc(5);
        wr(8'h0C);
        cyc(1);  chk("R4 old interval ignored", 32'(rd_data[6]), 32'h0);
        cyc(62); chk("R4 new interval before", 32'(rd_data[6]), 32'h0);
        cyc(1);  chk("R4 new interval at", 32'(rd_data[6]), 32'h1);

        // R7: request gating table, flag set by software, no reset enable
        wr(8'h00);
        glb_irq_en = 1'b1; irq_mask = 1'b1; irq_in_service = 1'b0;
        wr(8'h04);
        chk("R7 no request with flag clear", 32'(irq_req), 32'h0);
        wr(8'h00);
        foreach (GATE_VEC[i]) begin
            glb_irq_en     = GATE_VEC[i][3];
            irq_mask       = GATE_VEC[i][2];
            irq_in_service = GATE_VEC[i][1];
            wr(8'h40 | (8'(GATE_VEC[i][4]) << 2));
            chk($sformatf("R7 gating vector %0d", i), 32'(irq_req), 32'(GATE_VEC[i][0]));
            wr(8'h00);
        end
        glb_irq_en = 1'b0; irq_mask = 1'b0; irq_in_service = 1'b0;

        // R2/R6/R5: timeout with reset enabled
        do_por();
        wr(8'h06);
        cyc(519); chk("R2 no hold before 512 clocks", 32'(rst_hold), 32'h0);
        cyc(1);   chk("R2 hold 512 clocks after timeout", 32'(rst_hold), 32'h1);
        chk("R5 flag set by watchdog reset", 32'(rd_data[5]), 32'h1);
        cyc(11);  chk("R6 hold still high at clock 12", 32'(rst_hold), 32'h1);
        cyc(1);   chk("R6 hold low after 12 clocks", 32'(rst_hold), 32'h0);

        // R8: other reset keeps enables and reset flag, clears interrupt flag
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R8 value after other reset", 32'(rd_data), 32'h26);
        do_por();
        chk("R8 value after power-on reset", 32'(rd_data), 32'h80);

        // R10: cancel during countdown
        wr(8'h06);
        cyc(100);
        wr(8'h04);
        hold_never("R10 cancelled reset never fires", 700);
        chk("R10 no reset flag", 32'(rd_data[5]), 32'h0);

        // R2: software-set flag schedules the reset
        wr(8'h00);
        wr(8'h1A);
        wr(8'h5A);
        cyc(511); chk("R2 software flag, before", 32'(rst_hold), 32'h0);
        cyc(1);   chk("R2 software flag, at 512", 32'(rst_hold), 32'h1);
        cyc(12);  chk("R6 software path hold ended", 32'(rst_hold), 32'h0);

        // R5: writing the reset flag causes no reset
        do_por();
        wr(8'h20);
        hold_never("R5 written flag causes no reset", 600);
        chk("R5 written flag reads back", 32'(rd_data), 32'h20);

        // R4: select change during countdown has no effect
        do_por();
        wr(8'h06);
        cyc(100);
        wr(8'h4E);
        cyc(417); chk("R4 countdown unchanged, before", 32'(rst_hold), 32'h0);
        cyc(1);   chk("R4 countdown unchanged, at", 32'(rst_hold), 32'h1);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule